// File: doc/BRIEF.md
# Fundamental-Mode Settling Emulator

This block is a clocked, synthesizable stand-in for a two-variable asynchronous sequential circuit that runs in fundamental mode. The two feedback variables live in flip-flops. When an input value is taken in, the block evaluates the excitation functions once per clock and writes the excitation back into the state. It stops when the excitation equals the present state, which means the total state is stable. It then reports how many steps settling took, the settled state and a one-bit output.

While it settles, the block watches for the hazards of the asynchronous original. A step that needs both state variables to flip is a race. On such a step the block also settles the two orderings in which one variable flips before the other. If those orderings end in different states, it reports a critical race, and it still commits the parallel update. If the state has not settled after the step limit, it reports oscillation and freezes the state. An input that differs from the last accepted input in more than one bit is refused, because fundamental mode allows only one input to change at a time.

The excitation table is chosen at elaboration. Table 0 is the main circuit. Table 1 is a circuit with a race. Table 2 is a circuit that oscillates.

Top module: `asyncSettleEmu`

## Requirements
- R1: After reset, yState is 00, the held input is 00, settled is 1, stepCount is 0, and zOut, illegalChange, race, criticalRace, oscillation and busyDrop are all 0.
- R2: Table 0 takes x = inX[0], with y1 = yState[1] and y2 = yState[0]. The next y1 is x·y1 + x'·y2 and the next y2 is x·y1' + x'·y2. The stable total states (y1 y2 x) are 000, 011, 110 and 101, and zOut = y1.
- R3: The block applies one excitation step per clock. If an accepted input needs n steps (n ≤ 8), stepCount ends at n. settled goes low on the accept edge and goes high again n+1 edges after it. When settling ends without oscillation, the excitation equals the state.
- R4: Input is taken only while settled is 1. An inValid seen while settled is 0 changes nothing, and busyDrop is high for exactly the following cycle.
- R5: An inValid whose inX differs from the last accepted input in two or more bits is refused: yState, stepCount and the held input stay as they are. illegalChange rises after the next edge and stays high until an input is accepted.
- R6: A step in which both state variables must flip sets race, and the committed state is the parallel excitation. The race, criticalRace and oscillation flags are cleared by the next accepted input.
- R7: On a racing step, two orderings are settled for up to 8 parallel steps each: one starts with only y1 updated, the other with only y2 updated. criticalRace is set when their final states differ. criticalRace never appears without race.
- R8: If the state is still unstable after 8 steps, oscillation rises 9 edges after the accept edge. At the same edge settled rises, stepCount holds 8, and yState stays frozen until the next accepted input.
- R9: Table 1 takes x = inX[0]. With x = 0 every state goes to 00. With x = 1, state 00 goes to 11 and every other state is stable. zOut = y1·y2.
- R10: Table 2 takes x1 = inX[1] and x2 = inX[0]. The next y1 is (x1·y1)'·x2 and y2 stays 0, so the table oscillates when both inputs are 1. zOut = y1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Offers a new input value |
| inX | input | IN_W | Offered input bits |
| yState | output | 2 | Feedback variables {y1, y2} |
| zOut | output | 1 | Circuit output for the present state |
| settled | output | 1 | State is stable (or frozen); ready for input |
| stepCount | output | STEP_W | Steps taken since the last accepted input |
| illegalChange | output | 1 | Last offered input changed two or more bits |
| race | output | 1 | A step needed both variables to flip |
| criticalRace | output | 1 | The two single-flip orderings ended differently |
| oscillation | output | 1 | Step limit reached without a stable state |
| busyDrop | output | 1 | One-cycle pulse: input offered while settling was dropped |

## Verification
Counting the accept edge as edge 0, settled is due after edge n+1 for an n-step settle, or after edge 9 when the table oscillates. busyDrop is due after edge 1, and illegalChange after edge 0. The bench drives inputs on falling edges. It samples every output on each of the twelve falling edges that follow an offer, and compares settled on each of those edges with a done index it works out in advance. It reads the final state, count and flags on the last of those edges. Three instances, one per table, receive the same walk over every single-bit input change. The walk also includes an illegal double change and an offer made while the instances are busy.

// File: rtl/settleEmuPkg.sv
package settleEmuPkg;

  localparam int STATE_W = 2;

  typedef struct packed {
    logic accept;
    logic step;
    logic halt;
    logic reject;
    logic drop;
  } ctrlStrobe_t;

  typedef enum logic {
    ST_READY  = 1'b0,
    ST_SETTLE = 1'b1
  } ctrlState_t;

endpackage

// File: rtl/settleEmuExcite.sv
module settleEmuExcite #(
  parameter int TABLE_KIND = 0,
  parameter int IN_W       = 2
) (
  input  logic [IN_W-1:0] xIn,
  input  logic [1:0]      yIn,
  output logic [1:0]      yNext
);

  generate
    if (TABLE_KIND == 0) begin : g_tableMain
      wire unusedHighX = ^xIn[IN_W-1:1];
      assign yNext[1] = (xIn[0] & yIn[1]) | (~xIn[0] & yIn[0]);
      assign yNext[0] = (xIn[0] & ~yIn[1]) | (~xIn[0] & yIn[0]);
    end else if (TABLE_KIND == 1) begin : g_tableRace
      wire unusedHighX = ^xIn[IN_W-1:1];
      assign yNext = !xIn[0] ? 2'b00 : ((yIn == 2'b00) ? 2'b11 : yIn);
    end else begin : g_tableOsc
      wire unusedLowY = yIn[0];
      assign yNext[1] = ~(xIn[1] & yIn[1]) & xIn[0];
      assign yNext[0] = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/settleEmuChain.sv
module settleEmuChain #(
  parameter int TABLE_KIND = 0,
  parameter int IN_W       = 2,
  parameter int DEPTH      = 8
) (
  input  logic [IN_W-1:0] xIn,
  input  logic [1:0]      startY,
  output logic [1:0]      finalY
);

  logic [1:0] hop [DEPTH+1];

  assign hop[0] = startY;

  for (genvar i = 0; i < DEPTH; i++) begin : g_hop
    settleEmuExcite #(
      .TABLE_KIND(TABLE_KIND),
      .IN_W      (IN_W)
    ) u_exc (
      .xIn  (xIn),
      .yIn  (hop[i]),
      .yNext(hop[i+1])
    );
  end

  assign finalY = hop[DEPTH];

endmodule

// File: rtl/settleEmuDatapath.sv
module settleEmuDatapath
  import settleEmuPkg::*;
#(
  parameter int TABLE_KIND = 0,
  parameter int IN_W       = 2,
  parameter int MAX_STEPS  = 8,
  parameter int STEP_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [IN_W-1:0]   inX,
  output logic [1:0]        yState,
  output logic              zOut,
  output logic [STEP_W-1:0] stepCount,
  output logic              raceFlag,
  output logic              critFlag,
  output logic              oscFlag,
  output logic              illegalFlag,
  output logic              busyFlag,
  output logic              stableNow,
  output logic              limitHit,
  output logic              illegalIn
);

  logic [1:0]      yReg;
  logic [IN_W-1:0] xReg;
  logic [1:0]      yExc;
  logic [1:0]      orderA;
  logic [1:0]      orderB;
  logic [1:0]      finalA;
  logic [1:0]      finalB;
  logic            twoBit;
  logic [IN_W-1:0] inDiff;
  int unsigned     diffCount;

  settleEmuExcite #(
    .TABLE_KIND(TABLE_KIND),
    .IN_W      (IN_W)
  ) u_exc (
    .xIn  (xReg),
    .yIn  (yReg),
    .yNext(yExc)
  );

  // Orderings of a racing step: one variable flips, the other waits.
  assign orderA = {yExc[1], yReg[0]};
  assign orderB = {yReg[1], yExc[0]};

  settleEmuChain #(
    .TABLE_KIND(TABLE_KIND),
    .IN_W      (IN_W),
    .DEPTH     (MAX_STEPS)
  ) u_chainA (
    .xIn   (xReg),
    .startY(orderA),
    .finalY(finalA)
  );

  settleEmuChain #(
    .TABLE_KIND(TABLE_KIND),
    .IN_W      (IN_W),
    .DEPTH     (MAX_STEPS)
  ) u_chainB (
    .xIn   (xReg),
    .startY(orderB),
    .finalY(finalB)
  );

  assign twoBit    = &(yExc ^ yReg);
  assign stableNow = (yExc == yReg);
  assign limitHit  = (stepCount == STEP_W'(MAX_STEPS));
  assign inDiff    = inX ^ xReg;

  always_comb begin
    diffCount = 0;
    for (int i = 0; i < IN_W; i++) begin
      diffCount = diffCount + int'(inDiff[i]);
    end
  end

  assign illegalIn = (diffCount > 1);

  generate
    if (TABLE_KIND == 1) begin : g_zBoth
      assign zOut = yReg[1] & yReg[0];
    end else begin : g_zHigh
      assign zOut = yReg[1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      yReg        <= '0;
      xReg        <= '0;
      stepCount   <= '0;
      raceFlag    <= 1'b0;
      critFlag    <= 1'b0;
      oscFlag     <= 1'b0;
      illegalFlag <= 1'b0;
      busyFlag    <= 1'b0;
    end else begin
      busyFlag <= strobe.drop;
      if (strobe.accept) begin
        xReg        <= inX;
        stepCount   <= '0;
        raceFlag    <= 1'b0;
        critFlag    <= 1'b0;
        oscFlag     <= 1'b0;
        illegalFlag <= 1'b0;
      end
      if (strobe.reject) begin
        illegalFlag <= 1'b1;
      end
      if (strobe.step) begin
        yReg      <= yExc;
        stepCount <= stepCount + STEP_W'(1);
        if (twoBit) begin
          raceFlag <= 1'b1;
          if (finalA != finalB) begin
            critFlag <= 1'b1;
          end
        end
      end
      if (strobe.halt) begin
        oscFlag <= 1'b1;
      end
    end
  end

  assign yState = yReg;

  a_r5_reject_keeps_state: assert property (@(posedge clk) disable iff (rst)
    strobe.reject |=> ($stable(yReg) && $stable(xReg) && $stable(stepCount) && illegalFlag));

  a_r6_race_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (strobe.step && (yExc == ~yReg)) |=> (raceFlag && (yReg == $past(yExc))));

  a_r8_frozen_state: assert property (@(posedge clk) disable iff (rst)
    (oscFlag && !strobe.accept) |=> $stable(yReg));

  a_r3_step_bound: assert property (@(posedge clk) disable iff (rst)
    stepCount <= STEP_W'(MAX_STEPS));

endmodule

// File: rtl/settleEmuControl.sv
module settleEmuControl
  import settleEmuPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        stableNow,
  input  logic        limitHit,
  input  logic        illegalIn,
  output ctrlStrobe_t strobe,
  output logic        settled
);

  ctrlState_t state;
  ctrlState_t stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_READY: begin
        if (inValid) begin
          if (illegalIn) begin
            strobe.reject = 1'b1;
          end else begin
            strobe.accept = 1'b1;
            stateNext     = ST_SETTLE;
          end
        end
      end
      ST_SETTLE: begin
        strobe.drop = inValid;
        if (stableNow) begin
          stateNext = ST_READY;
        end else if (limitHit) begin
          strobe.halt = 1'b1;
          stateNext   = ST_READY;
        end else begin
          strobe.step = 1'b1;
        end
      end
      default: stateNext = ST_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_READY;
    end else begin
      state <= stateNext;
    end
  end

  assign settled = (state == ST_READY);

  a_r3_settle_on_stable: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_SETTLE) && stableNow) |=> settled);

  a_r4_busy_no_accept: assert property (@(posedge clk) disable iff (rst)
    (!settled && inValid) |=> !$rose(settled) || $past(stableNow) || $past(limitHit));

endmodule

// File: rtl/asyncSettleEmu.sv
module asyncSettleEmu
  import settleEmuPkg::*;
#(
  parameter int TABLE_KIND = 0,
  parameter int IN_W       = 2,
  parameter int MAX_STEPS  = 8,
  parameter int STEP_W     = $clog2(MAX_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [IN_W-1:0]   inX,
  output logic [1:0]        yState,
  output logic              zOut,
  output logic              settled,
  output logic [STEP_W-1:0] stepCount,
  output logic              illegalChange,
  output logic              race,
  output logic              criticalRace,
  output logic              oscillation,
  output logic              busyDrop
);

  ctrlStrobe_t strobe;
  logic        stableNow;
  logic        limitHit;
  logic        illegalIn;

  settleEmuControl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .stableNow(stableNow),
    .limitHit (limitHit),
    .illegalIn(illegalIn),
    .strobe   (strobe),
    .settled  (settled)
  );

  settleEmuDatapath #(
    .TABLE_KIND(TABLE_KIND),
    .IN_W      (IN_W),
    .MAX_STEPS (MAX_STEPS),
    .STEP_W    (STEP_W)
  ) u_data (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .inX        (inX),
    .yState     (yState),
    .zOut       (zOut),
    .stepCount  (stepCount),
    .raceFlag   (race),
    .critFlag   (criticalRace),
    .oscFlag    (oscillation),
    .illegalFlag(illegalChange),
    .busyFlag   (busyDrop),
    .stableNow  (stableNow),
    .limitHit   (limitHit),
    .illegalIn  (illegalIn)
  );

  a_r7_critical_needs_race: assert property (@(posedge clk) disable iff (rst)
    criticalRace |-> race);

  a_r3_settled_is_stable: assert property (@(posedge clk) disable iff (rst)
    (settled && !oscillation) |-> stableNow);

  a_r4_busy_pulse_once: assert property (@(posedge clk) disable iff (rst)
    busyDrop |=> (!busyDrop || !settled));

  a_r8_osc_at_limit: assert property (@(posedge clk) disable iff (rst)
    $rose(oscillation) |-> (settled && (stepCount == STEP_W'(MAX_STEPS))));

endmodule

// File: tb/sim_asyncSettleEmu.sv
module sim_asyncSettleEmu;

  localparam int CLK_PERIOD = 10;
  localparam int NINST      = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [1:0] inX = 2'b00;

  logic [1:0] yS   [NINST];
  logic       zS   [NINST];
  logic       setS [NINST];
  logic [3:0] stS  [NINST];
  logic       illS [NINST];
  logic       rcS  [NINST];
  logic       crS  [NINST];
  logic       osS  [NINST];
  logic       bdS  [NINST];

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asyncSettleEmu #(.TABLE_KIND(0)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inX(inX),
    .yState(yS[0]), .zOut(zS[0]), .settled(setS[0]), .stepCount(stS[0]),
    .illegalChange(illS[0]), .race(rcS[0]), .criticalRace(crS[0]),
    .oscillation(osS[0]), .busyDrop(bdS[0]));

  asyncSettleEmu #(.TABLE_KIND(1)) u1 (
    .clk(clk), .rst(rst), .inValid(inValid), .inX(inX),
    .yState(yS[1]), .zOut(zS[1]), .settled(setS[1]), .stepCount(stS[1]),
    .illegalChange(illS[1]), .race(rcS[1]), .criticalRace(crS[1]),
    .oscillation(osS[1]), .busyDrop(bdS[1]));

  asyncSettleEmu #(.TABLE_KIND(2)) u2 (
    .clk(clk), .rst(rst), .inValid(inValid), .inX(inX),
    .yState(yS[2]), .zOut(zS[2]), .settled(setS[2]), .stepCount(stS[2]),
    .illegalChange(illS[2]), .race(rcS[2]), .criticalRace(crS[2]),
    .oscillation(osS[2]), .busyDrop(bdS[2]));

  // Expected-state model per instance
  logic [1:0] mY   [NINST];
  logic [3:0] mSt  [NINST];
  logic       mRc  [NINST];
  logic       mCr  [NINST];
  logic       mOs  [NINST];
  logic       mIll [NINST];
  logic [1:0] mX;

  // Excitation from the requirement text: R2, R9, R10
  function automatic logic [1:0] exc(input int kind, input logic [1:0] x, input logic [1:0] y);
    logic [1:0] r;
    if (kind == 0) begin
      r[1] = (x[0] & y[1]) | (!x[0] & y[0]);
      r[0] = (x[0] & !y[1]) | (!x[0] & y[0]);
    end else if (kind == 1) begin
      r = (x[0] == 1'b0) ? 2'b00 : ((y == 2'b00) ? 2'b11 : y);
    end else begin
      r[1] = !(x[1] & y[1]) & x[0];
      r[0] = 1'b0;
    end
    return r;
  endfunction

  function automatic logic zOf(input int kind, input logic [1:0] y);
    return (kind == 1) ? (y[1] & y[0]) : y[1];
  endfunction

  function automatic logic [1:0] runOrder(input int kind, input logic [1:0] x, input logic [1:0] y0);
    logic [1:0] y = y0;
    for (int i = 0; i < 8; i++) y = exc(kind, x, y);
    return y;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Offer x; optionally offer a second value one cycle later (busy case)
  task automatic offer(input logic [1:0] x, input bit busy);
    int   doneAt [NINST];
    logic legal;
    legal = ($countones(x ^ mX) <= 1);
    for (int k = 0; k < NINST; k++) begin
      if (!legal) begin
        mIll[k]   = 1'b1;
        doneAt[k] = 0;
      end else begin
        logic [1:0] y = mY[k];
        int n = 0;
        mRc[k] = 1'b0; mCr[k] = 1'b0; mOs[k] = 1'b0; mIll[k] = 1'b0;
        for (int it = 0; it < 20; it++) begin
          logic [1:0] nx = exc(k, x, y);
          if (nx == y) break;
          if (n == 8) begin mOs[k] = 1'b1; break; end
          if ((nx ^ y) == 2'b11) begin
            mRc[k] = 1'b1;
            if (runOrder(k, x, {nx[1], y[0]}) != runOrder(k, x, {y[1], nx[0]}))
              mCr[k] = 1'b1;
          end
          y = nx;
          n++;
        end
        mY[k]     = y;
        mSt[k]    = 4'(n);
        doneAt[k] = mOs[k] ? 9 : n + 1;
      end
    end
    if (legal) mX = x;

    inX     = x;
    inValid = 1'b1;
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      if (j == 0) begin
        if (busy && legal) inX = ~x;
        else inValid = 1'b0;
      end else if (j == 1) begin
        inValid = 1'b0;
      end
      for (int k = 0; k < NINST; k++) begin
        bit expSet = !legal || (j >= doneAt[k]);
        bit expBd  = busy && legal && (j == 1);
        chk(setS[k] == expSet, $sformatf("R3 settled inst%0d cyc%0d", k, j), setS[k], expSet);
        chk(bdS[k] == expBd, $sformatf("R4 busyDrop inst%0d cyc%0d", k, j), bdS[k], expBd);
        if (!legal) begin
          chk(illS[k] == 1'b1, $sformatf("R5 illegal flag inst%0d", k), illS[k], 1);
          chk(yS[k] == mY[k], $sformatf("R5 state kept inst%0d", k), yS[k], mY[k]);
        end
      end
    end
    for (int k = 0; k < NINST; k++) begin
      string tbl = (k == 0) ? "R2" : ((k == 1) ? "R9" : "R10");
      chk(yS[k] == mY[k], $sformatf("%s yState inst%0d x=%0d", tbl, k, x), yS[k], mY[k]);
      chk(zS[k] == zOf(k, mY[k]), $sformatf("%s zOut inst%0d", tbl, k), zS[k], zOf(k, mY[k]));
      chk(stS[k] == mSt[k], $sformatf("R3 stepCount inst%0d", k), stS[k], mSt[k]);
      chk(rcS[k] == mRc[k], $sformatf("R6 race inst%0d", k), rcS[k], mRc[k]);
      chk(crS[k] == mCr[k], $sformatf("R7 criticalRace inst%0d", k), crS[k], mCr[k]);
      chk(osS[k] == mOs[k], $sformatf("R8 oscillation inst%0d", k), osS[k], mOs[k]);
      chk(illS[k] == mIll[k], $sformatf("R5 illegalChange inst%0d", k), illS[k], mIll[k]);
    end
  endtask

  initial begin
    mX = 2'b00;
    for (int k = 0; k < NINST; k++) begin
      mY[k] = 2'b00; mSt[k] = '0; mRc[k] = 1'b0; mCr[k] = 1'b0; mOs[k] = 1'b0; mIll[k] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int k = 0; k < NINST; k++) begin
      chk(yS[k] == 2'b00 && setS[k] && stS[k] == 0, $sformatf("R1 reset state inst%0d", k), yS[k], 0);
      chk(!(zS[k] | illS[k] | rcS[k] | crS[k] | osS[k] | bdS[k]),
          $sformatf("R1 reset flags inst%0d", k), 1, 0);
    end
    // Single-bit walk over the input square, both directions
    offer(2'b01, 0); offer(2'b11, 0); offer(2'b10, 0); offer(2'b00, 0);
    offer(2'b10, 0); offer(2'b11, 0); offer(2'b01, 0); offer(2'b00, 0);
    // R5 illegal double change, then recovery by a legal change
    offer(2'b11, 0);
    offer(2'b01, 0);
    // R4 offer during settling
    offer(2'b00, 1);
    offer(2'b01, 1);
    offer(2'b11, 1);
    // R5 illegal from 11, R8 re-entry of oscillation after a legal change
    offer(2'b00, 0);
    offer(2'b10, 0);
    offer(2'b11, 0);
    offer(2'b10, 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule